// File: doc/BRIEF.md
# Channel descriptor sequencer for ping-pong and scatter-gather transfers

This block sits beside a data-transfer engine and decides, for one channel at a time, which of the channel's two descriptors (primary or alternate) the engine works on next. A descriptor is four 32-bit words held in a table in system memory: the end address of the source, the end address of the destination, a control word and a spare word. The sequencer reads descriptors through a single memory port and hands the first three words to the engine with a one-cycle start pulse. When the engine reports that it has finished, the sequencer writes the control word back with its mode field set to stop.

In ping-pong operation the sequencer swaps to the other descriptor after each finished descriptor. It keeps going until it reaches a descriptor whose mode is stop. While one descriptor is running, software refills the other one. In scatter-gather operation the primary descriptor points at a list of four-word task entries. Each time the primary is selected, the sequencer itself copies the next entry into the alternate slot and decrements the primary's remaining-word count. It then runs the alternate descriptor on the engine. The sequence ends when a task in basic or auto mode completes. Moving the data items themselves is left to the engine.

Top module: `chan_desc_seq`

## Requirements
- R1: After reset, `busy`, `seq_done`, `eng_start` and `mem_req` are all low.
- R2: Word w (0 to 2) of channel c's descriptor is at address {tbl_base, sel, c, w, 2'b00}. Here sel is 0 for the primary and 1 for the alternate, so the alternate half starts 512 bytes above the primary half of the 1024-byte table. A sequence starts on the descriptor chosen by `start_alt`. In the control word, bits [2:0] are the mode, bit 3 is the burst-tail flag and bits [13:4] hold the remaining word count minus one.
- R3: When the mode is 1 (basic) or 2 (auto), the engine receives the source, destination and control words together with one `eng_start` pulse. After `eng_done`, the next cycle writes the control word back with bits [2:0] cleared and all other bits kept. `seq_done` then pulses for one cycle, and `busy` is low from the following cycle.
- R4: When the mode is 3 (ping-pong), the descriptor runs and is written back as in R3. The sequencer then reads the other descriptor of the channel and goes on. The sequence ends when the descriptor it reaches is in mode 0.
- R5: A sequence whose first descriptor is in mode 0 ends with `seq_done` without starting the engine and without writing memory.
- R6: A primary descriptor in mode 4 or 6 copies four words: word k (0 to 3) is read from src_end - 4*(n1-k) and written to dst_end - 12 + 4k, where n1 is bits [13:4]. The primary control word is then written back. If n1 > 3 the count becomes n1-4. Otherwise bits [13:4] and [2:0] become 0. The alternate descriptor is read next.
- R7: An alternate descriptor in mode 5 or 7 runs on the engine with `eng_alt` high. It is written back as stop, and the sequencer then returns to the primary descriptor.
- R8: A basic or auto task reached after at least one scatter-gather copy ends the sequence. `eng_burst_only` is high for that task exactly when bit 3 of the primary's control word was set at the last copy, and it is low for every other engine start.
- R9: A mode 5 or 7 found in the primary slot, or a mode 4 or 6 found in the alternate slot, ends the sequence with no engine start and no write.
- R10: A `start` pulse while `busy` is high has no effect on the running sequence.
- R11: `eng_start` is a one-cycle pulse, and there is no memory access while the engine is working on a descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 32-(CH_W+5) | Upper bits of the descriptor table base address |
| start | input | 1 | Pulse that begins a sequence when idle |
| start_chan | input | CH_W | Channel number for the sequence |
| start_alt | input | 1 | Begin on the alternate descriptor |
| busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | One-cycle pulse at the end of a sequence |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| eng_start | output | 1 | Hand the descriptor to the engine |
| eng_src | output | 32 | Source end address |
| eng_dst | output | 32 | Destination end address |
| eng_ctrl | output | 32 | Control word as read |
| eng_alt | output | 1 | The handed descriptor is the alternate one |
| eng_burst_only | output | 1 | Engine must answer burst requests only |
| eng_done | input | 1 | Engine has finished the descriptor |

## Verification
Each descriptor read takes two cycles, so the engine start follows a descriptor read by a fixed handful of cycles. The engine itself replies after 1 to 4 random cycles. For this reason the bench does not count cycles to each start. Instead it records every `eng_start` on the falling edge it is seen and compares the records afterwards with a bench-side model of the whole sequence. The write-back is due one cycle after `eng_done`, and `seq_done` is due two cycles after it for a closing basic task. The check that `busy` has fallen is made one falling edge after `seq_done` is seen. Memory, including the copied alternate slots, is compared only once the sequence has ended.

// File: rtl/dsq_pkg.sv
`timescale 1ns/1ps
package dsq_pkg;
  localparam int WORD_W    = 32;
  localparam int CNT_LSB   = 4;
  localparam int CNT_W     = 10;
  localparam int BURST_BIT = 3;
  localparam int NWORDS    = 3;

  localparam logic [2:0] MD_STOP    = 3'd0;
  localparam logic [2:0] MD_BASIC   = 3'd1;
  localparam logic [2:0] MD_AUTO    = 3'd2;
  localparam logic [2:0] MD_PP      = 3'd3;
  localparam logic [2:0] MD_MSG     = 3'd4;
  localparam logic [2:0] MD_MSG_ALT = 3'd5;
  localparam logic [2:0] MD_PSG     = 3'd6;
  localparam logic [2:0] MD_PSG_ALT = 3'd7;

  typedef enum logic [2:0] {ACT_END, ACT_LAST, ACT_PP, ACT_COPY, ACT_TASK} act_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_DECIDE, S_RUN, S_WAIT_ENG,
    S_WB, S_CP_RD, S_CP_WR, S_CP_UPD, S_FINISH
  } st_e;

  // control word with its mode field forced to stop
  function automatic logic [WORD_W-1:0] stop_word(input logic [WORD_W-1:0] c);
    return {c[WORD_W-1:3], 3'b000};
  endfunction

  // primary control word after one four-word task fetch
  function automatic logic [WORD_W-1:0] fetch_update(input logic [WORD_W-1:0] c);
    logic [CNT_W-1:0] n1;
    n1 = c[CNT_LSB +: CNT_W];
    if (n1 <= CNT_W'(3))
      return {c[WORD_W-1:CNT_LSB+CNT_W], {CNT_W{1'b0}}, c[BURST_BIT], 3'b000};
    else
      return {c[WORD_W-1:CNT_LSB+CNT_W], n1 - CNT_W'(4), c[CNT_LSB-1:0]};
  endfunction

  // word k of the current task entry, counted back from the list end
  function automatic logic [WORD_W-1:0] task_src_addr(input logic [WORD_W-1:0] src_end,
                                                      input logic [CNT_W-1:0] n1,
                                                      input logic [1:0] k);
    logic [WORD_W-1:0] back;
    back = {{(WORD_W-CNT_W){1'b0}}, n1} - {{(WORD_W-2){1'b0}}, k};
    return src_end - (back << 2);
  endfunction

  // word k of the four-word alternate slot ending at dst_end
  function automatic logic [WORD_W-1:0] task_dst_addr(input logic [WORD_W-1:0] dst_end,
                                                      input logic [1:0] k);
    return dst_end - WORD_W'(12) + {{(WORD_W-4){1'b0}}, k, 2'b00};
  endfunction
endpackage

// File: rtl/dsq_mode_dec.sv
`timescale 1ns/1ps
module dsq_mode_dec
  import dsq_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       sel,
  output act_e       act
);
  always_comb begin
    case (mode)
      MD_BASIC, MD_AUTO:     act = ACT_LAST;
      MD_PP:                 act = ACT_PP;
      MD_MSG, MD_PSG:        act = sel ? ACT_END  : ACT_COPY;
      MD_MSG_ALT, MD_PSG_ALT: act = sel ? ACT_TASK : ACT_END;
      default:               act = ACT_END;
    endcase
  end
endmodule

// File: rtl/dsq_addr_gen.sv
`timescale 1ns/1ps
module dsq_addr_gen
  import dsq_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic [WORD_W-1:CH_W+5] base,
  input  logic [CH_W-1:0]        ch,
  input  logic                   sel,
  input  logic [1:0]             widx,
  input  logic [WORD_W-1:0]      src_end,
  input  logic [WORD_W-1:0]      dst_end,
  input  logic [CNT_W-1:0]       n1,
  input  logic [1:0]             k,
  output logic [WORD_W-1:0]      rd_addr,
  output logic [WORD_W-1:0]      ctl_addr,
  output logic [WORD_W-1:0]      cp_src,
  output logic [WORD_W-1:0]      cp_dst
);
  assign rd_addr  = {base, sel, ch, widx, 2'b00};
  assign ctl_addr = {base, sel, ch, 2'd2, 2'b00};
  assign cp_src   = task_src_addr(src_end, n1, k);
  assign cp_dst   = task_dst_addr(dst_end, k);
endmodule

// File: rtl/dsq_desc_buf.sv
`timescale 1ns/1ps
module dsq_desc_buf
  import dsq_pkg::*;
#(
  parameter int NW = NWORDS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_en,
  input  logic [1:0]                cap_idx,
  input  logic [WORD_W-1:0]         cap_data,
  output logic [NW-1:0][WORD_W-1:0] words
);
  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              words[i] <= '0;
      else if (cap_en && (cap_idx == 2'(i)))   words[i] <= cap_data;
    end
  end
endmodule

// File: rtl/chan_desc_seq.sv
`timescale 1ns/1ps
module chan_desc_seq
  import dsq_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WORD_W-1:CH_W+5] tbl_base,
  input  logic                   start,
  input  logic [CH_W-1:0]        start_chan,
  input  logic                   start_alt,
  output logic                   busy,
  output logic                   seq_done,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [WORD_W-1:0]      mem_addr,
  output logic [WORD_W-1:0]      mem_wdata,
  input  logic [WORD_W-1:0]      mem_rdata,
  output logic                   eng_start,
  output logic [WORD_W-1:0]      eng_src,
  output logic [WORD_W-1:0]      eng_dst,
  output logic [WORD_W-1:0]      eng_ctrl,
  output logic                   eng_alt,
  output logic                   eng_burst_only,
  input  logic                   eng_done
);
  localparam logic [1:0] LAST_W = 2'(NWORDS - 1);

  st_e              st;
  act_e             act_now, act_q;
  logic             sel;
  logic [CH_W-1:0]  ch_q;
  logic [1:0]       widx, k;
  logic             sg_q, burst_q;
  logic [NWORDS-1:0][WORD_W-1:0] dw;
  logic [WORD_W-1:0] rd_addr, ctl_addr, cp_src, cp_dst;

  // named internal events
  logic eng_wait, task_run, wb_fire, cap_fire;
  assign eng_wait = (st == S_WAIT_ENG);
  assign task_run = (act_q == ACT_TASK);
  assign wb_fire  = (st == S_WB);
  assign cap_fire = (st == S_RD_WAIT);

  dsq_desc_buf #(.NW(NWORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_fire), .cap_idx(widx),
    .cap_data(mem_rdata), .words(dw)
  );

  dsq_mode_dec u_dec (.mode(dw[2][2:0]), .sel(sel), .act(act_now));

  dsq_addr_gen #(.CH_W(CH_W)) u_addr (
    .base(tbl_base), .ch(ch_q), .sel(sel), .widx(widx),
    .src_end(dw[0]), .dst_end(dw[1]), .n1(dw[2][CNT_LSB +: CNT_W]), .k(k),
    .rd_addr(rd_addr), .ctl_addr(ctl_addr), .cp_src(cp_src), .cp_dst(cp_dst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; act_q <= ACT_END; sel <= 1'b0; ch_q <= '0;
      widx <= '0; k <= '0; sg_q <= 1'b0; burst_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sel <= start_alt; ch_q <= start_chan; widx <= '0;
          sg_q <= 1'b0; burst_q <= 1'b0; st <= S_RD_REQ;
        end
        S_RD_REQ:  st <= S_RD_WAIT;
        S_RD_WAIT: begin
          if (widx == LAST_W) st <= S_DECIDE;
          else begin widx <= widx + 2'd1; st <= S_RD_REQ; end
        end
        S_DECIDE: begin
          act_q <= act_now;
          case (act_now)
            ACT_END:  st <= S_FINISH;
            ACT_COPY: begin
              k <= '0; sg_q <= 1'b1; burst_q <= dw[2][BURST_BIT]; st <= S_CP_RD;
            end
            default:  st <= S_RUN;
          endcase
        end
        S_RUN:      st <= S_WAIT_ENG;
        S_WAIT_ENG: if (eng_done) st <= S_WB;
        S_WB: begin
          widx <= '0;
          case (act_q)
            ACT_PP:   begin sel <= ~sel; st <= S_RD_REQ; end
            ACT_TASK: begin sel <= 1'b0; st <= S_RD_REQ; end
            default:  st <= S_FINISH;
          endcase
        end
        S_CP_RD: st <= S_CP_WR;
        S_CP_WR: begin
          if (k == 2'd3) st <= S_CP_UPD;
          else begin k <= k + 2'd1; st <= S_CP_RD; end
        end
        S_CP_UPD: begin sel <= 1'b1; widx <= '0; st <= S_RD_REQ; end
        S_FINISH: st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = rd_addr; mem_wdata = '0;
    case (st)
      S_RD_REQ: mem_req = 1'b1;
      S_CP_RD:  begin mem_req = 1'b1; mem_addr = cp_src; end
      S_CP_WR:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cp_dst; mem_wdata = mem_rdata; end
      S_WB:     begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ctl_addr; mem_wdata = stop_word(dw[2]); end
      S_CP_UPD: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ctl_addr; mem_wdata = fetch_update(dw[2]); end
      default:  ;
    endcase
  end

  assign busy           = (st != S_IDLE);
  assign seq_done       = (st == S_FINISH);
  assign eng_start      = (st == S_RUN);
  assign eng_src        = dw[0];
  assign eng_dst        = dw[1];
  assign eng_ctrl       = dw[2];
  assign eng_alt        = sel;
  assign eng_burst_only = sg_q & burst_q & (act_q == ACT_LAST);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> !eng_start); // R11
  AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rst_n) eng_wait |-> !mem_req); // R11
  AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) (eng_wait && eng_done) |=> (mem_req && mem_we)); // R3
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n) seq_done |=> !busy); // R3
  AST_TASK_ON_ALT: assert property (@(posedge clk) disable iff (!rst_n) (eng_start && task_run) |-> eng_alt); // R7
  AST_WB_STOPS: assert property (@(posedge clk) disable iff (!rst_n) wb_fire |=> !eng_start); // R11
endmodule

// File: tb/chan_desc_seq_test.sv
`timescale 1ns/1ps
module chan_desc_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:10] tbl_base = 22'h1;
  logic start = 1'b0, start_alt = 1'b0;
  logic [4:0] start_chan = '0;
  logic busy, seq_done, mem_req, mem_we, eng_start, eng_alt, eng_burst_only;
  logic eng_done = 1'b0;
  logic [31:0] mem_addr, mem_wdata, eng_src, eng_dst, eng_ctrl;
  logic [31:0] mem_rdata = '0;

  chan_desc_seq #(.CH_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .start(start),
    .start_chan(start_chan), .start_alt(start_alt), .busy(busy), .seq_done(seq_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .eng_start(eng_start), .eng_src(eng_src), .eng_dst(eng_dst),
    .eng_ctrl(eng_ctrl), .eng_alt(eng_alt), .eng_burst_only(eng_burst_only), .eng_done(eng_done)
  );

  logic [31:0] mem  [0:1023];
  logic [31:0] emem [0:1023];
  logic [31:0] lsrc [0:63], ldst [0:63], lctl [0:63];
  logic        lalt [0:63], lbst [0:63];
  logic [31:0] esrc [0:63], edst [0:63], ectl [0:63];
  logic        ealt [0:63], ebst [0:63];
  int n_log, en, n_chk, n_fail, trial_no, cur_ch, cur_refills, cur_t;
  bit poke_req, quiet_err, long_start, finished;
  int cyc;

  // memory with registered read
  initial forever begin
    @(posedge clk);
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  function automatic int slot_idx(input int ch, input bit alt);
    return 256 + (alt ? 128 : 0) + ch * 4;
  endfunction

  function automatic logic [31:0] refill_word(input int t, input int i, input int r, input int w);
    logic [2:0] m;
    m = (i == r - 1 && t[0]) ? 3'd1 : 3'd3;
    case (w)
      0:       return 32'h1000_0000 + 32'(t * 4096 + i * 16);
      1:       return 32'h2000_0000 + 32'(t * 4096 + i * 16);
      default: return {18'h2A5A5 ^ 18'(t), 10'((t * 7 + i * 3) & 1023), 1'(i & 1), m};
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // bench-side model of one sequence on emem
  task automatic model_seq(input int ch, input bit alt, input int refills, input int t);
    bit s, sg, bst;
    int a, o;
    logic [31:0] c, src, dst;
    logic [2:0] m;
    int n1;
    s = alt; sg = 0; bst = 0; en = 0;
    for (int g = 0; g < 200; g++) begin
      a = slot_idx(ch, s);
      c = emem[a + 2]; m = c[2:0];
      if (m == 1 || m == 2 || m == 3 || ((m == 5 || m == 7) && s)) begin
        if (en < 64) begin
          esrc[en] = emem[a]; edst[en] = emem[a + 1]; ectl[en] = c;
          ealt[en] = s; ebst[en] = sg && bst && (m == 1 || m == 2);
        end
        if (en < refills) begin
          o = slot_idx(ch, !s);
          for (int w = 0; w < 3; w++) emem[o + w] = refill_word(t, en, refills, w);
        end
        en++;
        emem[a + 2] = {c[31:3], 3'b000};
        if (m == 1 || m == 2) break;
        s = (m == 3) ? !s : 1'b0;
      end else if ((m == 4 || m == 6) && !s) begin
        n1 = int'(c[13:4]); src = emem[a]; dst = emem[a + 1];
        for (int kk = 0; kk < 4; kk++)
          emem[(dst - 12 + 32'(4 * kk)) >> 2] = emem[(src - 32'(4 * (n1 - kk))) >> 2];
        if (n1 <= 3) emem[a + 2] = {c[31:14], 10'd0, c[3], 3'b000};
        else         emem[a + 2] = {c[31:14], 10'(n1 - 4), c[3:0]};
        sg = 1; bst = c[3]; s = 1;
      end else break;
    end
  endtask

  // engine model
  int o_e, d_e;
  initial begin
    forever begin
      @(negedge clk);
      if (eng_start) begin
        if (n_log < 64) begin
          lsrc[n_log] = eng_src; ldst[n_log] = eng_dst; lctl[n_log] = eng_ctrl;
          lalt[n_log] = eng_alt; lbst[n_log] = eng_burst_only;
        end
        if (n_log < cur_refills) begin
          o_e = slot_idx(cur_ch, !eng_alt);
          for (int w = 0; w < 3; w++) mem[o_e + w] = refill_word(cur_t, n_log, cur_refills, w);
        end
        if (poke_req) begin
          poke_req = 0; start = 1; start_chan = 5'(cur_ch + 1); start_alt = !eng_alt;
        end
        n_log++;
        d_e = $urandom_range(1, 4);
        for (int j = 0; j < d_e; j++) begin
          @(negedge clk);
          start = 0;
          if (eng_start) long_start = 1;
          if (mem_req) quiet_err = 1;
        end
        eng_done = 1;
        @(negedge clk);
        eng_done = 0;
      end
    end
  end

  task automatic run_trial(input string tlog, input string tmem, input int ch,
                           input bit alt, input int refills, input bit poke);
    bit got;
    int bad, first;
    for (int i = 0; i < 1024; i++) emem[i] = mem[i];
    model_seq(ch, alt, refills, trial_no);
    cur_ch = ch; cur_refills = refills; cur_t = trial_no; poke_req = poke;
    n_log = 0; quiet_err = 0; long_start = 0;
    @(negedge clk); start = 1; start_chan = 5'(ch); start_alt = alt;
    @(negedge clk); start = 0;
    got = 0;
    for (int c = 0; c < 3000 && !got; c++) begin
      if (seq_done) got = 1; else @(negedge clk);
    end
    check(got, tlog, "sequence end", 32'(got), 32'd1);
    @(negedge clk);
    check(busy == 1'b0, "R3", "busy after done", 32'(busy), 32'd0);
    check(n_log == en, tlog, "engine start count", 32'(n_log), 32'(en));
    for (int i = 0; i < en && i < 64 && i < n_log; i++) begin
      check(lsrc[i] == esrc[i] && ldst[i] == edst[i] && lctl[i] == ectl[i] && lalt[i] == ealt[i],
            tlog, $sformatf("engine record %0d ctrl", i), lctl[i], ectl[i]);
      check(lbst[i] == ebst[i], "R8", $sformatf("burst-only on start %0d", i),
            32'(lbst[i]), 32'(ebst[i]));
    end
    bad = 0; first = 0;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== emem[i]) begin if (bad == 0) first = i; bad++; end
    check(bad == 0, tmem, $sformatf("memory word %0d", first), mem[first], emem[first]);
    check(!quiet_err && !long_start, "R11", "engine start pulse and quiet port",
          32'({quiet_err, long_start}), 32'd0);
    trial_no++;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  task automatic put_desc(input int ch, input bit alt, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] c);
    mem[slot_idx(ch, alt)] = s; mem[slot_idx(ch, alt) + 1] = d; mem[slot_idx(ch, alt) + 2] = c;
  endtask

  function automatic logic [31:0] rnd_ctrl(input logic [2:0] m);
    logic [31:0] r;
    r = $urandom;
    return {r[31:3], m};
  endfunction

  task automatic setup_sg(input int ch, input int ntask, input bit burst, input bit last_auto);
    logic [2:0] m;
    for (int t = 0; t < ntask; t++) begin
      if (t == ntask - 1) m = last_auto ? 3'd2 : 3'd1;
      else m = $urandom_range(0, 1) ? 3'd5 : 3'd7;
      mem[512 + t * 4]     = $urandom;
      mem[512 + t * 4 + 1] = $urandom;
      mem[512 + t * 4 + 2] = rnd_ctrl(m);
      mem[512 + t * 4 + 3] = $urandom;
    end
    put_desc(ch, 0, 32'h800 + 32'(16 * ntask - 4), 32'h600 + 32'(ch * 16 + 12),
             {14'(($urandom) & 16383), 4'h0, 10'(4 * ntask - 1), burst,
              ($urandom_range(0, 1) ? 3'd4 : 3'd6)});
  endtask

  task automatic setup_pp(input int ch);
    put_desc(ch, 0, $urandom, $urandom, rnd_ctrl(3'd3));
    put_desc(ch, 1, $urandom, $urandom, rnd_ctrl(3'd3));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    int ty, ch, nt;
    void'($urandom(32'd20240611));
    n_chk = 0; n_fail = 0; trial_no = 0; finished = 0;
    cur_refills = 0; poke_req = 0;
    clear_mem();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !seq_done && !eng_start && !mem_req, "R1", "idle outputs after reset",
          32'({busy, seq_done, eng_start, mem_req}), 32'd0);

    // R5 stop descriptor at the start
    clear_mem();
    run_trial("R5", "R5", 7, 0, 0, 0);
    // R2 / R3 basic on channel 0 primary, auto on channel 31 alternate
    clear_mem();
    put_desc(0, 0, 32'hA000_0010, 32'hB000_0020, 32'h0000_1231);
    run_trial("R3", "R2", 0, 0, 0, 0);
    clear_mem();
    put_desc(31, 1, 32'hA111_0000, 32'hB222_0000, 32'hFFFF_F00A);
    run_trial("R2", "R3", 31, 1, 0, 0);
    // R9 scatter-gather modes in the wrong slot
    clear_mem();
    put_desc(3, 0, 32'h1, 32'h2, 32'h0000_0075);
    run_trial("R9", "R9", 3, 0, 0, 0);
    clear_mem();
    put_desc(4, 1, 32'h1, 32'h2, 32'h0000_0036);
    run_trial("R9", "R9", 4, 1, 0, 0);
    // R4 ping-pong with refills, R10 start while busy
    clear_mem(); setup_pp(9);
    run_trial("R4", "R4", 9, 0, 3, 0);
    clear_mem(); setup_pp(12);
    run_trial("R10", "R10", 12, 1, 2, 1);
    // R6 / R7 / R8 scatter-gather with burst tail
    clear_mem(); setup_sg(5, 3, 1, 1);
    run_trial("R7", "R6", 5, 0, 0, 0);
    clear_mem(); setup_sg(30, 1, 1, 0);
    run_trial("R7", "R6", 30, 0, 0, 0);

    // constrained random mix
    for (int r = 0; r < 40; r++) begin
      clear_mem();
      ty = $urandom_range(0, 2);
      ch = $urandom_range(0, 31);
      if (ty == 0) begin
        setup_pp(ch);
        run_trial("R4", "R4", ch, 1'($urandom_range(0, 1)), $urandom_range(0, 4), 1'($urandom_range(0, 1)));
      end else if (ty == 1) begin
        nt = $urandom_range(1, 5);
        setup_sg(ch, nt, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        run_trial("R7", "R6", ch, 0, 0, 0);
      end else begin
        put_desc(ch, r[0], $urandom, $urandom, rnd_ctrl(r[1] ? 3'd1 : 3'd2));
        run_trial("R3", "R2", ch, r[0], 0, 0);
      end
    end
    finish_run();
  end
endmodule